// File: doc/BRIEF.md
# Sprite Line Evaluator

This block decides which sprites take part in each scanline. It keeps a local cache of 80 sprite attribute records. The cache is filled by watching writes to video RAM: when a word is written inside the sprite attribute table, the matching part of the matching record is updated. No separate load step is needed.

At the start of each visible line the block walks the records as a linked list. The walk starts at record 0 and follows each record's link field. It examines one record per clock and collects up to 20 records whose vertical span covers the line. The walk stops at the first of these:
- a visible sprite at X position zero,
- a link that is zero or out of range,
- a full list.

When the walk ends, a done flag rises. The pixel stage then reads the collected records by index. Lines past the visible area give an empty list, and the first of them raises a one-cycle end-of-frame pulse.

Top module: `spr_line_eval`

## Requirements
- R1: A write with word address A updates the cache only when `attr_base <= A < attr_base + 320`. With offset O = A - attr_base, record O>>2 is updated, and O[1:0] selects which of the record's four words is written. Writes outside that window change nothing.
- R2: Word 0 bits 9:0 give Y and word 3 bits 9:0 give X. Each is the raw value minus 128, reported modulo 1024 on 10-bit outputs.
- R3: Word 1 gives the link (bits 6:0), the height (bits 9:8 times 8) and the width (bits 11:10 times 8). Word 2 gives the pattern address (bits 10:0 shifted left by 4), horizontal flip (bit 11), vertical flip (bit 12), palette (bits 14:13) and priority (bit 15).
- R4: For a line below 240, the walk examines record 0 first and then always the record named by the current link, including after a sprite that was not visible. Collected records appear at indices 0, 1, 2, ... in walk order.
- R5: With y9 = Y[8:0] and h the height, a record is visible on line L unless (y9+h-1) mod 512 < L or (L+h-1) mod 512 < y9.
- R6: A visible record whose X equals 0 ends the walk and is not collected. A record that is not visible and has X = 0 does not end the walk.
- R7: No more than 20 records are collected. The walk ends as soon as the 20th is collected.
- R8: After a record is examined and the walk has not already ended, a link of 0 or of 80 or more ends the walk.
- R9: One record is examined per clock. `eval_done` is low from the cycle after `line_start` until the cycle after the last examined record, and then stays high until the next `line_start`. At most 80 records are examined per line.
- R10: A `line_start` with a line number of 240 or more gives an empty list and `eval_done` high on the next cycle. A line number of exactly 240 also raises `frame_end` for that one cycle.
- R11: After reset, `eval_done`, `frame_end` and `hit_count` are 0, and every cache word and list slot holds zero raw data. A list slot read back after reset therefore shows Y = X = 0x380 and all other fields 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snoop_we | input | 1 | Video RAM word write strobe |
| snoop_addr | input | 15 | Word address of the snooped write |
| snoop_data | input | 16 | Data of the snooped write |
| attr_base | input | 15 | Word address of the start of the attribute table |
| line_start | input | 1 | One-cycle request to evaluate `line_num` |
| line_num | input | 9 | Scanline to evaluate |
| eval_done | output | 1 | Walk finished, list valid |
| hit_count | output | 5 | Number of collected records |
| frame_end | output | 1 | One-cycle pulse for line 240 |
| sel_idx | input | 5 | List index read by the pixel stage |
| spr_y | output | 10 | Y of the selected record |
| spr_x | output | 10 | X of the selected record |
| spr_height | output | 5 | Height in lines |
| spr_width | output | 5 | Width in pixels |
| spr_pattern | output | 15 | Pattern address |
| spr_hflip | output | 1 | Horizontal flip |
| spr_vflip | output | 1 | Vertical flip |
| spr_palette | output | 2 | Palette select |
| spr_priority | output | 1 | Priority bit |

## Verification
The walk is tried on several kinds of table:
- A short chain that jumps over an invisible record. This separates following links from scanning in table order.
- A visible record at X zero. This shows termination happens before the record is added.
- A chain of 25 visible records, which shows the cap at 20.
- Links of 0 and of 85, which show the two range exits.
- An invisible self-loop, which shows the 80-record guard.

Random tables with heights of zero and wrapped Y values test the 9-bit compare against a bench model. The same model checks the cycle count to done. Lines 240 and above, and a moved table base, cover the frame-end pulse and the address window.

// File: rtl/spr_eval_pkg.sv
package spr_eval_pkg;

    // Raw attribute record as cached from the four table words
    typedef struct packed {
        logic [9:0]  y_raw;
        logic [9:0]  x_raw;
        logic [6:0]  link;
        logic [1:0]  hsz;
        logic [1:0]  wsz;
        logic [10:0] pat;
        logic        hflip;
        logic        vflip;
        logic [1:0]  pal;
        logic        prio;
    } spr_attr_t;

    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_RUN  = 1'b1
    } walk_st_e;

    localparam logic [9:0] COORD_OFS = 10'd128;

    function automatic logic [4:0] size_px(input logic [1:0] sz);
        return {sz, 3'b000};
    endfunction

    function automatic logic [9:0] coord(input logic [9:0] raw);
        return raw - COORD_OFS;
    endfunction

endpackage

// File: rtl/spr_attr_cache.sv
module spr_attr_cache
    import spr_eval_pkg::*;
#(
    parameter int NUM_ENTRIES = 80,
    parameter int AW          = 15,
    parameter int IW          = $clog2(NUM_ENTRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [15:0]   wr_data,
    input  logic [AW-1:0] base,
    input  logic [IW-1:0] rd_idx,
    output spr_attr_t     rd_ent
);
    localparam int TABLE_WORDS = NUM_ENTRIES * 4;

    typedef struct packed {
        spr_attr_t [NUM_ENTRIES-1:0] ent;
    } cache_t;

    cache_t        c_d, c_q;
    logic [AW:0]   ofs;
    logic          in_win;
    logic [IW-1:0] wr_idx;
    logic [1:0]    wr_word;

    always_comb begin
        c_d     = c_q;
        ofs     = {1'b0, wr_addr} - {1'b0, base};
        in_win  = (wr_addr >= base) && (ofs < (AW+1)'(TABLE_WORDS));
        wr_idx  = ofs[IW+1:2];
        wr_word = ofs[1:0];
        if (wr_en && in_win) begin
            unique case (wr_word)
                2'd0: c_d.ent[wr_idx].y_raw = wr_data[9:0];
                2'd1: begin
                    c_d.ent[wr_idx].link = wr_data[6:0];
                    c_d.ent[wr_idx].hsz  = wr_data[9:8];
                    c_d.ent[wr_idx].wsz  = wr_data[11:10];
                end
                2'd2: begin
                    c_d.ent[wr_idx].pat   = wr_data[10:0];
                    c_d.ent[wr_idx].hflip = wr_data[11];
                    c_d.ent[wr_idx].vflip = wr_data[12];
                    c_d.ent[wr_idx].pal   = wr_data[14:13];
                    c_d.ent[wr_idx].prio  = wr_data[15];
                end
                default: c_d.ent[wr_idx].x_raw = wr_data[9:0];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    always_comb begin
        if (rd_idx < IW'(NUM_ENTRIES)) begin
            rd_ent = c_q.ent[rd_idx];
        end else begin
            rd_ent = '0;
        end
    end

endmodule

// File: rtl/spr_line_walker.sv
module spr_line_walker
    import spr_eval_pkg::*;
#(
    parameter int NUM_ENTRIES = 80,
    parameter int MAX_HITS    = 20,
    parameter int VIS_LINES   = 240,
    parameter int IW          = $clog2(NUM_ENTRIES),
    parameter int SW          = $clog2(NUM_ENTRIES + 1),
    parameter int CW          = $clog2(MAX_HITS + 1),
    parameter int PW          = $clog2(MAX_HITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_start,
    input  logic [8:0]    line_num,
    input  spr_attr_t     ent_i,
    output logic [IW-1:0] ent_idx_o,
    output logic          push_o,
    output logic [PW-1:0] push_idx_o,
    output spr_attr_t     push_rec_o,
    output logic [CW-1:0] count_o,
    output logic          done_o,
    output logic          frame_end_o
);
    localparam logic [CW-1:0] MAX_C   = CW'(MAX_HITS);
    localparam logic [SW-1:0] STEPS_C = SW'(NUM_ENTRIES);
    localparam logic [8:0]    VIS_C   = 9'(VIS_LINES);
    localparam logic [6:0]    LINK_C  = 7'(NUM_ENTRIES);

    typedef struct packed {
        walk_st_e      st;
        logic [IW-1:0] cur;
        logic [SW-1:0] steps;
        logic [CW-1:0] count;
        logic [8:0]    line;
        logic          done;
        logic          frame_end;
    } walk_t;

    walk_t         w_d, w_q;
    logic [9:0]    ent_y, ent_x;
    logic [4:0]    ent_h;
    logic [8:0]    y_bot, line_bot;
    logic          vis;
    logic          stop;
    logic          push;
    logic [CW-1:0] cnt_inc;
    logic [SW-1:0] steps_inc;

    always_comb begin
        w_d           = w_q;
        w_d.frame_end = 1'b0;
        push          = 1'b0;
        stop          = 1'b0;
        ent_y         = coord(ent_i.y_raw);
        ent_x         = coord(ent_i.x_raw);
        ent_h         = size_px(ent_i.hsz);
        y_bot         = ent_y[8:0] + {4'b0, ent_h} - 9'd1;
        line_bot      = w_q.line + {4'b0, ent_h} - 9'd1;
        vis           = !(y_bot < w_q.line) && !(line_bot < ent_y[8:0]);
        cnt_inc       = w_q.count + 1'b1;
        steps_inc     = w_q.steps + 1'b1;

        if (line_start) begin
            w_d.count     = '0;
            w_d.cur       = '0;
            w_d.steps     = '0;
            w_d.line      = line_num;
            w_d.frame_end = (line_num == VIS_C);
            if (line_num < VIS_C) begin
                w_d.st   = WALK_RUN;
                w_d.done = 1'b0;
            end else begin
                w_d.st   = WALK_IDLE;
                w_d.done = 1'b1;
            end
        end else if (w_q.st == WALK_RUN) begin
            if (vis) begin
                if (ent_x == 10'd0) begin
                    stop = 1'b1;
                end else begin
                    push      = 1'b1;
                    w_d.count = cnt_inc;
                    if (cnt_inc == MAX_C) begin
                        stop = 1'b1;
                    end
                end
            end
            if (!stop) begin
                if ((ent_i.link == 7'd0) || (ent_i.link >= LINK_C) ||
                    (steps_inc == STEPS_C)) begin
                    stop = 1'b1;
                end else begin
                    w_d.cur   = IW'(ent_i.link);
                    w_d.steps = steps_inc;
                end
            end
            if (stop) begin
                w_d.st   = WALK_IDLE;
                w_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q <= '{st: WALK_IDLE, cur: '0, steps: '0, count: '0,
                     line: '0, done: 1'b0, frame_end: 1'b0};
        end else begin
            w_q <= w_d;
        end
    end

    assign ent_idx_o   = w_q.cur;
    assign push_o      = push;
    assign push_idx_o  = PW'(w_q.count);
    assign push_rec_o  = ent_i;
    assign count_o     = w_q.count;
    assign done_o      = w_q.done;
    assign frame_end_o = w_q.frame_end;

endmodule

// File: rtl/spr_hit_list.sv
module spr_hit_list
    import spr_eval_pkg::*;
#(
    parameter int MAX_HITS = 20,
    parameter int PW       = $clog2(MAX_HITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [PW-1:0] push_idx,
    input  spr_attr_t     push_rec,
    input  logic [PW-1:0] rd_idx,
    output spr_attr_t     rd_rec
);
    typedef struct packed {
        spr_attr_t [MAX_HITS-1:0] slot;
    } list_t;

    list_t l_d, l_q;

    always_comb begin
        l_d = l_q;
        if (push && (push_idx < PW'(MAX_HITS))) begin
            l_d.slot[push_idx] = push_rec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_q <= '0;
        end else begin
            l_q <= l_d;
        end
    end

    always_comb begin
        if (rd_idx < PW'(MAX_HITS)) begin
            rd_rec = l_q.slot[rd_idx];
        end else begin
            rd_rec = '0;
        end
    end

endmodule

// File: rtl/spr_line_eval.sv
module spr_line_eval
    import spr_eval_pkg::*;
#(
    parameter int NUM_ENTRIES = 80,
    parameter int MAX_HITS    = 20,
    parameter int VIS_LINES   = 240,
    parameter int AW          = 15,
    parameter int CW          = $clog2(MAX_HITS + 1),
    parameter int PW          = $clog2(MAX_HITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          snoop_we,
    input  logic [AW-1:0] snoop_addr,
    input  logic [15:0]   snoop_data,
    input  logic [AW-1:0] attr_base,
    input  logic          line_start,
    input  logic [8:0]    line_num,
    output logic          eval_done,
    output logic [CW-1:0] hit_count,
    output logic          frame_end,
    input  logic [PW-1:0] sel_idx,
    output logic [9:0]    spr_y,
    output logic [9:0]    spr_x,
    output logic [4:0]    spr_height,
    output logic [4:0]    spr_width,
    output logic [14:0]   spr_pattern,
    output logic          spr_hflip,
    output logic          spr_vflip,
    output logic [1:0]    spr_palette,
    output logic          spr_priority
);
    localparam int IW = $clog2(NUM_ENTRIES);

    spr_attr_t     cache_ent;
    logic [IW-1:0] cache_idx;
    logic          push;
    logic [PW-1:0] push_idx;
    spr_attr_t     push_rec;
    spr_attr_t     sel_rec;

    spr_attr_cache #(
        .NUM_ENTRIES(NUM_ENTRIES),
        .AW         (AW)
    ) u_cache (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (snoop_we),
        .wr_addr(snoop_addr),
        .wr_data(snoop_data),
        .base   (attr_base),
        .rd_idx (cache_idx),
        .rd_ent (cache_ent)
    );

    spr_line_walker #(
        .NUM_ENTRIES(NUM_ENTRIES),
        .MAX_HITS   (MAX_HITS),
        .VIS_LINES  (VIS_LINES)
    ) u_walker (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .line_num   (line_num),
        .ent_i      (cache_ent),
        .ent_idx_o  (cache_idx),
        .push_o     (push),
        .push_idx_o (push_idx),
        .push_rec_o (push_rec),
        .count_o    (hit_count),
        .done_o     (eval_done),
        .frame_end_o(frame_end)
    );

    spr_hit_list #(
        .MAX_HITS(MAX_HITS)
    ) u_list (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push),
        .push_idx(push_idx),
        .push_rec(push_rec),
        .rd_idx  (sel_idx),
        .rd_rec  (sel_rec)
    );

    assign spr_y        = coord(sel_rec.y_raw);
    assign spr_x        = coord(sel_rec.x_raw);
    assign spr_height   = size_px(sel_rec.hsz);
    assign spr_width    = size_px(sel_rec.wsz);
    assign spr_pattern  = {sel_rec.pat, 4'b0000};
    assign spr_hflip    = sel_rec.hflip;
    assign spr_vflip    = sel_rec.vflip;
    assign spr_palette  = sel_rec.pal;
    assign spr_priority = sel_rec.prio;

endmodule

// File: rtl/spr_line_eval_chk.sv
module spr_line_eval_chk #(
    parameter int NUM_ENTRIES = 80,
    parameter int MAX_HITS    = 20,
    parameter int VIS_LINES   = 240,
    parameter int CW          = $clog2(MAX_HITS + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          line_start,
    input logic [8:0]    line_num,
    input logic          eval_done,
    input logic [CW-1:0] hit_count,
    input logic          frame_end
);
    localparam int WCW = $clog2(NUM_ENTRIES + 2);

    logic           walk_act_q;
    logic [WCW-1:0] walk_cyc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_act_q <= 1'b0;
            walk_cyc_q <= '0;
        end else if (line_start) begin
            walk_act_q <= (line_num < 9'(VIS_LINES));
            walk_cyc_q <= '0;
        end else if (walk_act_q) begin
            if (eval_done) begin
                walk_act_q <= 1'b0;
            end else begin
                walk_cyc_q <= walk_cyc_q + 1'b1;
            end
        end
    end

    // R7
    count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_count <= CW'(MAX_HITS));

    // R9
    walk_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_cyc_q <= WCW'(NUM_ENTRIES));

    // R9
    done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && (line_num < 9'(VIS_LINES))) |=> !eval_done);

    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_done && !line_start) |=> eval_done);

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> ((hit_count == $past(hit_count)) ||
                         (hit_count == $past(hit_count) + 1'b1)));

    // R10
    offscreen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && (line_num >= 9'(VIS_LINES))) |=> (eval_done && (hit_count == '0)));

    // R10
    frame_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && (line_num == 9'(VIS_LINES))) |=> frame_end);

    // R10
    frame_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> $past(line_start));

endmodule

bind spr_line_eval spr_line_eval_chk #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .MAX_HITS   (MAX_HITS),
    .VIS_LINES  (VIS_LINES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_start(line_start),
    .line_num  (line_num),
    .eval_done (eval_done),
    .hit_count (hit_count),
    .frame_end (frame_end)
);

// File: tb/spr_line_eval_test.sv
`timescale 1ns/1ps
module spr_line_eval_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        snoop_we = 1'b0;
    logic [14:0] snoop_addr = '0;
    logic [15:0] snoop_data = '0;
    logic [14:0] attr_base = '0;
    logic        line_start = 1'b0;
    logic [8:0]  line_num = '0;
    logic        eval_done;
    logic [4:0]  hit_count;
    logic        frame_end;
    logic [4:0]  sel_idx = '0;
    logic [9:0]  spr_y, spr_x;
    logic [4:0]  spr_height, spr_width;
    logic [14:0] spr_pattern;
    logic        spr_hflip, spr_vflip, spr_priority;
    logic [1:0]  spr_palette;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [15:0] shadow [0:319];
    logic [49:0] exp_rec [0:19];
    int          exp_cnt;
    int          exp_steps;
    bit          exp_fe;

    always #4 clk = ~clk;

    spr_line_eval uut (
        .clk(clk), .rst_n(rst_n), .snoop_we(snoop_we), .snoop_addr(snoop_addr),
        .snoop_data(snoop_data), .attr_base(attr_base), .line_start(line_start),
        .line_num(line_num), .eval_done(eval_done), .hit_count(hit_count),
        .frame_end(frame_end), .sel_idx(sel_idx), .spr_y(spr_y), .spr_x(spr_x),
        .spr_height(spr_height), .spr_width(spr_width), .spr_pattern(spr_pattern),
        .spr_hflip(spr_hflip), .spr_vflip(spr_vflip), .spr_palette(spr_palette),
        .spr_priority(spr_priority)
    );

    function automatic logic [49:0] act_rec();
        return {spr_y, spr_x, spr_height, spr_width, spr_pattern,
                spr_hflip, spr_vflip, spr_palette, spr_priority};
    endfunction

    task automatic chk(input bit ok, input string what, input logic [49:0] act,
                       input logic [49:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    task automatic wr(input logic [14:0] addr, input logic [15:0] data);
        logic [15:0] ofs;
        @(negedge clk);
        snoop_we = 1'b1; snoop_addr = addr; snoop_data = data;
        @(negedge clk);
        snoop_we = 1'b0;
        ofs = {1'b0, addr} - {1'b0, attr_base};
        if (addr >= attr_base && ofs < 16'd320) shadow[ofs] = data;
    endtask

    task automatic set_ent(input int i, input int y, input int x, input int link,
                           input int hsz, input logic [15:0] w2);
        wr(attr_base + 15'(i*4 + 0), 16'(y + 128));
        wr(attr_base + 15'(i*4 + 1), 16'(link) | 16'(hsz << 8) | 16'h0400);
        wr(attr_base + 15'(i*4 + 2), w2);
        wr(attr_base + 15'(i*4 + 3), 16'(x + 128));
    endtask

    // Walk model built from R2 R3 R4 R5 R6 R7 R8 R9 R10
    task automatic model(input logic [8:0] line);
        exp_cnt = 0; exp_steps = 0; exp_fe = (line == 9'd240);
        if (line < 9'd240) begin
            int  cur = 0;
            bit  run = 1;
            while (run) begin
                logic [15:0] w0, w1, w2, w3;
                logic [9:0]  yv, xv;
                logic [4:0]  h, wd;
                logic [8:0]  lo, hi;
                bit          vis;
                w0 = shadow[cur*4]; w1 = shadow[cur*4+1];
                w2 = shadow[cur*4+2]; w3 = shadow[cur*4+3];
                exp_steps++;
                yv = w0[9:0] - 10'd128; xv = w3[9:0] - 10'd128;
                h = {w1[9:8], 3'b0}; wd = {w1[11:10], 3'b0};
                lo = yv[8:0] + 9'(h) - 9'd1;
                hi = line + 9'(h) - 9'd1;
                vis = !(lo < line) && !(hi < yv[8:0]);
                if (vis) begin
                    if (xv == 10'd0) run = 0;
                    else begin
                        exp_rec[exp_cnt] = {yv, xv, h, wd, {w2[10:0], 4'b0},
                                            w2[11], w2[12], w2[14:13], w2[15]};
                        exp_cnt++;
                        if (exp_cnt == 20) run = 0;
                    end
                end
                if (run) begin
                    if (w1[6:0] == 7'd0 || w1[6:0] >= 7'd80 || exp_steps == 80) run = 0;
                    else cur = int'(w1[6:0]);
                end
            end
        end
    endtask

    task automatic run_line(input logic [8:0] line, input string tag);
        int cyc;
        model(line);
        @(negedge clk);
        line_start = 1'b1; line_num = line;
        @(negedge clk);
        line_start = 1'b0;
        chk(frame_end == exp_fe, {tag, " R10 frame_end"}, 50'(frame_end), 50'(exp_fe));
        cyc = 0;
        while (!eval_done && cyc < 400) begin
            @(negedge clk);
            cyc++;
        end
        chk(cyc == exp_steps, {tag, " R9 cycles to done"}, 50'(cyc), 50'(exp_steps));
        chk(hit_count == 5'(exp_cnt), {tag, " R4 R7 hit count"}, 50'(hit_count), 50'(exp_cnt));
        for (int i = 0; i < exp_cnt; i++) begin
            sel_idx = 5'(i);
            #1;
            chk(act_rec() == exp_rec[i], {tag, " R1 R2 R3 R5 record"}, act_rec(), exp_rec[i]);
        end
        if (exp_fe) begin
            @(negedge clk);
            chk(frame_end == 1'b0, {tag, " R10 pulse length"}, 50'(frame_end), 50'd0);
        end
    endtask

    task automatic fill_random();
        for (int a = 0; a < 320; a++) begin
            logic [15:0] d;
            int r;
            d = 16'($urandom);
            case (a % 4)
                0: d[9:0] = 10'(128 + ($urandom % 250));
                1: begin
                    r = int'($urandom % 10);
                    if (r == 0) d[6:0] = 7'd0;
                    else if (r == 1) d[6:0] = 7'(80 + ($urandom % 48));
                    else d[6:0] = 7'(1 + ($urandom % 79));
                end
                3: d[9:0] = (($urandom % 12) == 0) ? 10'd128 : 10'(129 + ($urandom % 300));
                default: ;
            endcase
            wr(attr_base + 15'(a), d);
        end
    endtask

    initial begin
        void'($urandom(32'd24681357));
        for (int a = 0; a < 320; a++) shadow[a] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(eval_done == 1'b0, "R11 done after reset", 50'(eval_done), 50'd0);
        chk(hit_count == 5'd0, "R11 count after reset", 50'(hit_count), 50'd0);
        chk(frame_end == 1'b0, "R11 frame_end after reset", 50'(frame_end), 50'd0);
        #1;
        chk(act_rec() == {10'h380, 10'h380, 30'd0}, "R11 slot after reset",
            act_rec(), {10'h380, 10'h380, 30'd0});
        run_line(9'd10, "R11 empty cache");

        // R4 chain skipping an invisible record
        set_ent(0, 100, 50, 3, 1, 16'hA123);
        set_ent(3, 200, 60, 5, 1, 16'h5FFF);
        set_ent(5, 95, 70, 0, 1, 16'h1801);
        run_line(9'd100, "R4");
        // R8 link zero ends it, line 96 only sees record 5? also 0
        run_line(9'd96, "R8");

        // R6 visible X zero stops, invisible X zero does not
        set_ent(0, 40, 10, 1, 1, 16'h0011);
        set_ent(1, 150, 0, 2, 1, 16'h0022);
        set_ent(2, 40, 20, 4, 1, 16'h0033);
        set_ent(4, 40, 0, 6, 1, 16'h0044);
        set_ent(6, 40, 30, 0, 1, 16'h0055);
        run_line(9'd45, "R6");

        // R7 chain of 25 visible records
        for (int i = 0; i < 25; i++) set_ent(i, 60, 5 + i, (i == 24) ? 0 : i + 1, 2, 16'(i * 97));
        run_line(9'd70, "R7");

        // R8 link out of range
        set_ent(0, 60, 9, 85, 1, 16'h7777);
        run_line(9'd61, "R8");

        // R9 invisible self loop hits the 80-record guard
        set_ent(0, 200, 9, 1, 0, 16'h0);
        set_ent(1, 200, 9, 1, 0, 16'h0);
        run_line(9'd20, "R9");

        // R10 offscreen lines
        run_line(9'd240, "R10");
        run_line(9'd300, "R10");

        // R1 moved base: writes outside the new window are ignored
        attr_base = 15'h1000;
        for (int a = 0; a < 320; a++) shadow[a] = 16'hxxxx;
        for (int a = 0; a < 320; a++) wr(15'h1000 + 15'(a), (a % 4 == 1) ? 16'd0 : 16'd0);
        set_ent(0, 30, 12, 79, 1, 16'hBEEF);
        set_ent(79, 30, 14, 0, 1, 16'hCAFE);
        wr(15'h0FFF, 16'h0180);
        wr(15'h1000 + 15'd320, 16'h0180);
        wr(15'h0FFC, 16'h0000);
        run_line(9'd33, "R1");

        // random tables and lines
        for (int r = 0; r < 6; r++) begin
            fill_random();
            for (int k = 0; k < 8; k++) run_line(9'($urandom % 240), "R5 random");
            run_line(9'(240 + ($urandom % 22)), "R10 random");
        end

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule